// File: doc/BRIEF.md
# Dual-Format Serial Audio Transmitter

This block turns a stereo pair of parallel capture samples into a serial bit stream for a host that owns the clocks. The host drives the bit clock and the frame clock. The block runs on its own system clock. It brings both host clocks into that domain through synchroniser chains and detects their edges there. Every output bit is launched from a registered output on a detected falling bit-clock edge, most significant bit first.

Two framings are selectable with `fmt_dsp`:
- **Left/right framing (`fmt_dsp`=0):** each frame-clock level carries one channel. Low carries the left channel and high carries the right channel. Every frame-clock transition begins a new word one bit period later.
- **Early-pulse framing (`fmt_dsp`=1):** only a rising frame-clock edge matters. The left word begins one bit period after that edge, and the right word follows it without a gap.

In both framings the line is held at zero from the last sent bit until the next frame event.

Samples arrive over a load port with a ready flag. One pair may wait in a holding stage. At each frame start the waiting pair is taken as the frame's pair. If no pair is waiting, the previous pair is sent again and an underrun flag is raised.

Top module: `sat_tx`

## Requirements
- R1: While reset is held and just after it is released, `sdata` is 0, `load_ready` is 1 and `underrun` is 0.
- R2: With `fmt_dsp`=0, every frame-clock transition starts a word. The word's MSB is driven on the first falling bit-clock edge after the transition, so a receiver sampling on rising edges sees it on the second rising edge. A falling edge that coincides with the transition does not count. The left word goes out while the frame clock is low and the right word while it is high.
- R3: With `fmt_dsp`=1, a rising frame-clock edge starts a frame. The left MSB is driven on the first falling bit-clock edge after that rising edge. The right MSB follows the left LSB on the very next falling edge. A falling frame-clock edge has no effect.
- R4: `sdata` changes only in the system-clock cycle after a detected falling bit-clock edge, and each word is sent MSB first.
- R5: After the last bit of a word (left/right framing) or of the pair (early-pulse framing), `sdata` is 0 on every following bit until the next frame event.
- R6: The pair sent in a frame is fixed at the frame start. In left/right framing the frame start is the falling frame-clock edge; in early-pulse framing it is the rising edge. Loads made later in the frame, including during the left half in left/right framing, do not change the bits of that frame.
- R7: `load_ready` is 1 when no pair is waiting. A cycle with `load_valid` and `load_ready` both high stores the pair and drops `load_ready` on the next cycle. A `load_valid` while `load_ready` is 0 is ignored. `load_ready` rises again only after a frame start takes the waiting pair.
- R8: At a frame start with no waiting pair, `underrun` becomes 1 and the previously sent pair is sent again. At a frame start that takes a waiting pair, `underrun` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bclk | input | 1 | Bit clock from the host, asynchronous |
| lrclk | input | 1 | Frame clock from the host, asynchronous |
| fmt_dsp | input | 1 | 0 selects left/right framing, 1 selects early-pulse framing |
| load_valid | input | 1 | Offers a sample pair |
| load_left | input | W | Left sample offered |
| load_right | input | W | Right sample offered |
| load_ready | output | 1 | High when the holding stage is empty |
| sdata | output | 1 | Serial data, MSB first |
| underrun | output | 1 | High after a frame start that found no new pair |

## Verification
On every cycle, the bound checker confirms several properties:
- `sdata` moves only after a detected falling bit-clock edge.
- The line drops to zero once the shifter has run out of bits.
- The ready flag falls after an accepted load and rises only at a frame start.
- `underrun` can only become 1 at a frame start.

Other behaviours need the bench's scenarios, because they depend on data and framing:
- the exact bit order and position relative to the frame clock in both framings;
- the gap-free right word in early-pulse framing;
- the independence of a frame from mid-frame loads;
- the repeat of the old pair after an underrun.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic {
    FMT_LR  = 1'b0,
    FMT_DSP = 1'b1
  } sat_fmt_e;

  function automatic logic edge_rose(input logic level, input logic prev);
    return level & ~prev;
  endfunction

  function automatic logic edge_fell(input logic level, input logic prev);
    return ~level & prev;
  endfunction

  // Any event that begins a new word on the line.
  function automatic logic word_event(input sat_fmt_e fmt, input logic rise, input logic fall);
    return (fmt == FMT_DSP) ? rise : (rise | fall);
  endfunction

  // Event at which a new sample pair is taken.
  function automatic logic pair_event(input sat_fmt_e fmt, input logic rise, input logic fall);
    return (fmt == FMT_DSP) ? rise : fall;
  endfunction

  // Number of bits launched per word event.
  function automatic int burst_len(input sat_fmt_e fmt, input int w);
    return (fmt == FMT_DSP) ? 2 * w : w;
  endfunction

endpackage

// File: rtl/sat_edge_sync.sv
module sat_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic prev
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[DEPTH-2:0], async_in};
  end

  assign level = pipe_q[STAGES-1];
  assign prev  = pipe_q[STAGES];
endmodule

// File: rtl/sat_pair_hold.sv
module sat_pair_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_valid,
  input  logic [W-1:0] load_left,
  input  logic [W-1:0] load_right,
  input  logic         take,
  output logic         load_ready,
  output logic [W-1:0] cur_left,
  output logic [W-1:0] cur_right,
  output logic         underrun
);
  logic [W-1:0] wait_left_q, wait_right_q;
  logic         wait_full_q;
  logic         accept_w;

  assign accept_w   = load_valid & ~wait_full_q;
  assign load_ready = ~wait_full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_left_q  <= '0;
      wait_right_q <= '0;
      wait_full_q  <= 1'b0;
      cur_left     <= '0;
      cur_right    <= '0;
      underrun     <= 1'b0;
    end else begin
      if (accept_w) begin
        wait_left_q  <= load_left;
        wait_right_q <= load_right;
        wait_full_q  <= 1'b1;
      end
      if (take) begin
        if (wait_full_q) begin
          cur_left    <= wait_left_q;
          cur_right   <= wait_right_q;
          wait_full_q <= 1'b0;
          underrun    <= 1'b0;
        end else begin
          underrun    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sat_shifter.sv
module sat_shifter #(
  parameter int W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        launch,
  input  logic                        bit_fall,
  input  logic [2*W-1:0]              burst,
  input  logic [$clog2(2*W+1)-1:0]    burst_bits,
  output logic                        sdata,
  output logic                        idle
);
  localparam int SW = 2 * W;
  localparam int CW = $clog2(SW + 1);

  logic [SW-1:0] sh_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      sdata  <= 1'b0;
    end else if (launch) begin
      sdata  <= burst[SW-1];
      sh_q   <= {burst[SW-2:0], 1'b0};
      left_q <= burst_bits - CW'(1);
    end else if (bit_fall) begin
      if (left_q != '0) begin
        sdata  <= sh_q[SW-1];
        sh_q   <= {sh_q[SW-2:0], 1'b0};
        left_q <= left_q - CW'(1);
      end else begin
        sdata  <= 1'b0;
      end
    end
  end

  assign idle = (left_q == '0);
endmodule

// File: rtl/sat_tx.sv
module sat_tx #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk,
  input  logic         lrclk,
  input  logic         fmt_dsp,
  input  logic         load_valid,
  input  logic [W-1:0] load_left,
  input  logic [W-1:0] load_right,
  output logic         load_ready,
  output logic         sdata,
  output logic         underrun
);
  import sat_pkg::*;

  localparam int SW = 2 * W;
  localparam int CW = $clog2(SW + 1);

  sat_fmt_e fmt;
  assign fmt = sat_fmt_e'(fmt_dsp);

  logic bclk_lvl, bclk_prev, lr_lvl, lr_prev;

  sat_edge_sync #(.STAGES(SYNC_STAGES)) u_bclk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(bclk), .level(bclk_lvl), .prev(bclk_prev)
  );
  sat_edge_sync #(.STAGES(SYNC_STAGES)) u_lr_sync (
    .clk(clk), .rst_n(rst_n), .async_in(lrclk), .level(lr_lvl), .prev(lr_prev)
  );

  // Named internal events
  logic bit_fall_w, lr_rise_w, lr_fall_w;
  logic word_event_w, frame_start_w, launch_w, idle_w;

  assign bit_fall_w    = edge_fell(bclk_lvl, bclk_prev);
  assign lr_rise_w     = edge_rose(lr_lvl, lr_prev);
  assign lr_fall_w     = edge_fell(lr_lvl, lr_prev);
  assign word_event_w  = word_event(fmt, lr_rise_w, lr_fall_w);
  assign frame_start_w = pair_event(fmt, lr_rise_w, lr_fall_w);

  // Pending word: armed by an event, launched by the next distinct fall
  logic pend_q, pend_right_q;

  assign launch_w = pend_q & bit_fall_w & ~word_event_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q       <= 1'b0;
      pend_right_q <= 1'b0;
    end else if (word_event_w) begin
      pend_q       <= 1'b1;
      pend_right_q <= (fmt == FMT_LR) & lr_lvl;
    end else if (launch_w) begin
      pend_q       <= 1'b0;
    end
  end

  logic [W-1:0] cur_left, cur_right;

  sat_pair_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load_valid(load_valid), .load_left(load_left), .load_right(load_right),
    .take(frame_start_w),
    .load_ready(load_ready), .cur_left(cur_left), .cur_right(cur_right),
    .underrun(underrun)
  );

  logic [SW-1:0] burst_w;
  logic [CW-1:0] burst_bits_w;

  always_comb begin
    if (fmt == FMT_DSP) burst_w = {cur_left, cur_right};
    else                burst_w = {(pend_right_q ? cur_right : cur_left), {W{1'b0}}};
    burst_bits_w = CW'(burst_len(fmt, W));
  end

  sat_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .launch(launch_w), .bit_fall(bit_fall_w),
    .burst(burst_w), .burst_bits(burst_bits_w),
    .sdata(sdata), .idle(idle_w)
  );
endmodule

// File: rtl/sat_tx_chk.sv
module sat_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic load_valid,
  input logic load_ready,
  input logic sdata,
  input logic underrun,
  input logic bit_fall,
  input logic launch,
  input logic frame_start,
  input logic idle
);
  assert_out_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $past(bit_fall));

  assert_tail_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_fall && idle && !launch) |=> !sdata);

  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && load_ready) |=> !load_ready);

  assert_ready_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_ready) |-> $past(frame_start));

  assert_underrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(frame_start));
endmodule

bind sat_tx sat_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
  .sdata(sdata), .underrun(underrun), .bit_fall(bit_fall_w), .launch(launch_w),
  .frame_start(frame_start_w), .idle(idle_w)
);

// File: tb/sat_tx_test.sv
module sat_tx_test;
  localparam int W     = 16;
  localparam int SLOTS = 64;

  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b1, lrclk = 1'b1, fmt_dsp = 1'b0;
  logic load_valid = 1'b0;
  logic [W-1:0] load_left = '0, load_right = '0;
  wire load_ready, sdata, underrun;

  sat_tx #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .fmt_dsp(fmt_dsp),
    .load_valid(load_valid), .load_left(load_left), .load_right(load_right),
    .load_ready(load_ready), .sdata(sdata), .underrun(underrun)
  );

  always #5 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // Bench model of the pair path
  logic [W-1:0] m_wait_l, m_wait_r, m_cur_l, m_cur_r;
  bit m_full, m_und;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected sample seen at rising edge j of a frame
  function automatic logic [SLOTS-1:0] expect_stream(input bit dsp, input logic [W-1:0] l,
                                                     input logic [W-1:0] r);
    logic [SLOTS-1:0] s = '0;
    for (int j = 1; j <= W; j++) begin
      s[j] = l[W-j];
      if (dsp) s[W+j]         = r[W-j];
      else     s[SLOTS/2+j]   = r[W-j];
    end
    return s;
  endfunction

  task automatic bit_cycle(input logic lr_val, output logic smp);
    @(negedge clk);
    bclk  = 1'b0;
    lrclk = lr_val;
    repeat (8) @(negedge clk);
    smp  = sdata;
    bclk = 1'b1;
    repeat (7) @(negedge clk);
  endtask

  task automatic do_load(input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    check("R7 ready before load", 64'(load_ready), 64'(!m_full));
    load_valid = 1'b1;
    load_left  = l;
    load_right = r;
    @(negedge clk);
    load_valid = 1'b0;
    if (!m_full) begin
      m_wait_l = l; m_wait_r = r; m_full = 1'b1;
    end
    check("R7 ready after load", 64'(load_ready), 64'(0));
  endtask

  task automatic do_reset(input bit dsp);
    rst_n = 1'b0; fmt_dsp = dsp; bclk = 1'b1; lrclk = dsp ? 1'b0 : 1'b1; load_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 sdata in reset", 64'(sdata), 64'(0));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 sdata after reset", 64'(sdata), 64'(0));
    check("R1 ready after reset", 64'(load_ready), 64'(1));
    check("R1 underrun after reset", 64'(underrun), 64'(0));
    m_wait_l = '0; m_wait_r = '0; m_cur_l = '0; m_cur_r = '0; m_full = 1'b0; m_und = 1'b0;
  endtask

  task automatic run_frame(input bit dsp, input int at1, input logic [W-1:0] l1, input logic [W-1:0] r1,
                           input int at2, input logic [W-1:0] l2, input logic [W-1:0] r2);
    logic [SLOTS-1:0] cap, exp;
    logic lr, smp;
    if (m_full) begin
      m_cur_l = m_wait_l; m_cur_r = m_wait_r; m_full = 1'b0; m_und = 1'b0;
    end else begin
      m_und = 1'b1;
    end
    exp = expect_stream(dsp, m_cur_l, m_cur_r);
    cap = '0;
    for (int j = 0; j < SLOTS; j++) begin
      if (dsp) lr = (j == 0);
      else     lr = (j >= SLOTS/2);
      bit_cycle(lr, smp);
      cap[j] = smp;
      if (j == 4) begin
        check("R8 underrun at frame start", 64'(underrun), 64'(m_und));
        check("R7 ready after frame start", 64'(load_ready), 64'(!m_full));
      end
      if (j == at1) do_load(l1, r1);
      if (j == at2) do_load(l2, r2);
    end
    if (dsp) begin
      check("R3,R4,R5,R6 early-pulse frame", 64'(cap), 64'(exp));
    end else begin
      check("R2,R4,R5,R6 left half", 64'(cap[SLOTS/2-1:0]), 64'(exp[SLOTS/2-1:0]));
      check("R2,R4,R5,R6 right half", 64'(cap[SLOTS-1:SLOTS/2]), 64'(exp[SLOTS-1:SLOTS/2]));
    end
  endtask

  task automatic phase(input bit dsp);
    do_reset(dsp);
    run_frame(dsp, 10, 16'hFFFF, 16'h0001, -1, '0, '0);      // R8 underrun, zeros
    run_frame(dsp, 20, 16'hA5C3, 16'h8000, 21, 16'h1234, 16'h5678); // R6 mid-frame load, R7 ignored
    run_frame(dsp, -1, '0, '0, -1, '0, '0);                   // sends A5C3/8000
    run_frame(dsp, 40, 16'h0F0F, 16'hF0F0, -1, '0, '0);       // R8 repeat of previous pair
    for (int k = 0; k < 12; k++) begin
      int at;
      logic [W-1:0] l, r;
      at = (($urandom % 4) == 0) ? -1 : 5 + int'($urandom % 55);
      l  = W'($urandom);
      r  = W'($urandom);
      run_frame(dsp, at, l, r, -1, '0, '0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    phase(1'b0);
    phase(1'b1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule